// File: doc/BRIEF.md
# Cascadable Dual Pulse Timer

This block produces square-wave style pulse trains from two byte-wide down counters. Each channel alternates between a low phase and a high phase, and each phase length comes from its own reload register. At each prescaler tick the counter steps down by one. When it steps past zero it wraps, the output level flips and the counter reloads for the phase that follows. A mode bit joins the two counters into one double-width counter, so that longer pulses can be made. In that mode channel 0's control register governs the joined counter.

Each channel has a byte-wide control register. It holds a run bit, a pin-select bit, an interrupt-enable bit and a sticky wrap flag. The flag bit always reads as 1 while the bus marks the access as read-modify-write. Software can therefore write back the whole byte without clearing a flag it did not mean to touch. Each output pin carries either the pulse or a general-purpose port value. The interrupt request is the flag gated by its enable.

Top module: `cascade_pulse_timer`

## Requirements
- R1: After reset every register reads 0, except the control registers (addresses 0 and 1), which read 0x01. `irq` is low and each `pin_out` equals its `gpio_out` bit.
- R2: Control bit 7 (run) enables counting. While run is 0 the counter holds its value, and if bit 5 is 1 the pin is driven Low.
- R3: When control bit 5 (pin select) is 0, `pin_out` equals `gpio_out` for that channel whatever the counter does. When it is 1, `pin_out` carries the pulse.
- R4: `irq[i]` is high exactly while channel i's flag (bit 3) and interrupt enable (bit 4) are both 1.
- R5: With mode register (address 6) bit 0 clear, each channel counts on its own `tick_in` bit. A low phase lasts low-reload+1 ticks (low reload at address 2+2i) and a high phase lasts high-reload+1 ticks (high reload at address 3+2i). The wrap from 0x00 to 0xFF flips the output and loads the reload value of the next phase.
- R6: With mode bit 0 set, the counters form one 16-bit counter, with channel 1 as the high byte. It runs on `tick_in[0]` under channel 0's run bit, and the reload values are {ch1, ch0}. Only the 16-bit wrap from 0x0000 flips the output and sets channel 0's flag. Channel 1's flag is not set, and `pin_out[1]` carries the same pulse when its bit 5 is 1.
- R7: A wrap sets the flag. Writing 0 to bit 3 clears it, and writing 1 leaves it unchanged.
- R8: If a wrap and a write of 0 to bit 3 fall in the same cycle, the flag ends up set.
- R9: While `bus_rmw` is high, bit 3 of a control register read is 1.
- R10: Bits 6, 2 and 1 of a control register ignore writes and read 0. Bit 0 reads 1 whatever is written.
- R11: When run goes from 0 to 1, the counter loads the low reload value and the output starts Low. The first rising edge of the output follows low-reload+1 ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rmw | input | 1 | Marks the access as read-modify-write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| tick_in | input | 2 | Prescaler tick, one per channel |
| gpio_out | input | 2 | Port value for pins not used by the timer |
| pin_out | output | 2 | Pin level per channel |
| irq | output | 2 | Interrupt request per channel |

## Verification
A counter that is off by one or reloads from the wrong register shows up at the first phase edge, as a wrong tick count between two pin transitions. A borrow that does not pass from the low byte to the high byte shows up in 16-bit mode as a phase length that is wrong by multiples of 256. A flag that fails to set, clear or hold shows on `irq` and on a read in the very next cycle. A missing read-modify-write override shows on the same read.

// File: rtl/cpt_pkg.sv
package cpt_pkg;
   localparam int NCH = 2;

   localparam int B_RUN  = 7;
   localparam int B_PSEL = 5;
   localparam int B_IEN  = 4;
   localparam int B_FLAG = 3;
   localparam int B_RSV  = 0;

   typedef struct packed {
      logic run;
      logic psel;
      logic ien;
      logic flag;
   } ctrl_t;
endpackage

// File: rtl/cpt_ctrl_reg.sv
module cpt_ctrl_reg
   import cpt_pkg::*;
#(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr,
   input  logic          rmw,
   input  logic [DW-1:0] wdata,
   input  logic          wrap,
   output ctrl_t         ctrl,
   output logic [DW-1:0] rdata
);
   ctrl_t c_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         c_q <= '0;
      end else begin
         if (wr) begin
            c_q.run  <= wdata[B_RUN];
            c_q.psel <= wdata[B_PSEL];
            c_q.ien  <= wdata[B_IEN];
         end
         // hardware set has priority over a software clear
         if (wrap)
            c_q.flag <= 1'b1;
         else if (wr && !wdata[B_FLAG])
            c_q.flag <= 1'b0;
      end
   end

   always_comb begin
      rdata         = '0;
      rdata[B_RUN]  = c_q.run;
      rdata[B_PSEL] = c_q.psel;
      rdata[B_IEN]  = c_q.ien;
      rdata[B_FLAG] = c_q.flag | rmw;
      rdata[B_RSV]  = 1'b1;
   end

   assign ctrl = c_q;

   // R8: a wrap always leaves the flag set
   a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> c_q.flag);
   // R7: a write of 0 without a wrap clears
   a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && !wdata[B_FLAG] && !wrap) |=> !c_q.flag);
   // R7: a write of 1 never clears a set flag
   a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (c_q.flag && wr && wdata[B_FLAG]) |=> c_q.flag);
endmodule

// File: rtl/cpt_count_core.sv
module cpt_count_core
   import cpt_pkg::*;
#(
   parameter int DW         = 8,
   parameter bit CASCADE_EN = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    cascade,
   input  logic [NCH-1:0]          run,
   input  logic [NCH-1:0]          tick,
   input  logic [NCH-1:0][DW-1:0]  lo_w,
   input  logic [NCH-1:0][DW-1:0]  hi_w,
   output logic [NCH-1:0]          pulse,
   output logic [NCH-1:0]          wrap
);
   logic                   casc;
   logic [NCH-1:0][DW-1:0] cnt;
   logic [NCH-1:0]         ph;
   logic [NCH-1:0]         run_q;
   logic [NCH-1:0]         eff_run;
   logic [NCH-1:0]         eff_tick;
   logic [NCH-1:0]         start;
   logic [NCH-1:0]         step;
   logic                   wide_zero;

   generate
      if (CASCADE_EN) begin : g_casc
         assign casc = cascade;
      end else begin : g_nocasc
         logic unused_casc;
         assign unused_casc = cascade;
         assign casc        = 1'b0;
      end
   endgenerate

   assign eff_run[0]  = run[0];
   assign eff_tick[0] = tick[0];
   assign eff_run[1]  = casc ? run[0]  : run[1];
   assign eff_tick[1] = casc ? tick[0] : tick[1];
   assign start       = eff_run & ~run_q;
   assign step        = eff_run & eff_tick & ~start;
   assign wide_zero   = (cnt == '0);

   always_comb begin
      if (casc) begin
         wrap[0] = step[0] & wide_zero;
         wrap[1] = 1'b0;
      end else begin
         for (int i = 0; i < NCH; i++)
            wrap[i] = step[i] & (cnt[i] == '0);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         ph    <= '0;
         run_q <= '0;
      end else begin
         run_q <= eff_run;
         if (casc) begin
            if (start[0]) begin
               cnt <= lo_w;
               ph  <= '0;
            end else if (step[0]) begin
               if (wide_zero) begin
                  ph  <= {NCH{~ph[0]}};
                  cnt <= ph[0] ? lo_w : hi_w;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
         end else begin
            for (int i = 0; i < NCH; i++) begin
               if (start[i]) begin
                  cnt[i] <= lo_w[i];
                  ph[i]  <= 1'b0;
               end else if (step[i]) begin
                  if (cnt[i] == '0) begin
                     ph[i]  <= ~ph[i];
                     cnt[i] <= ph[i] ? lo_w[i] : hi_w[i];
                  end else begin
                     cnt[i] <= cnt[i] - 1'b1;
                  end
               end
            end
         end
      end
   end

   assign pulse = eff_run & ph;

   generate
      for (genvar g = 0; g < NCH; g++) begin : g_chk
         // R2: a stopped counter holds its value
         a_r2_freeze: assert property (@(posedge clk) disable iff (!rst_n)
            !eff_run[g] |=> $stable(cnt[g]));
         // R11: a fresh start begins in the low phase
         a_r11_start_low: assert property (@(posedge clk) disable iff (!rst_n)
            start[g] |=> !ph[g]);
         // R5: every wrap flips the phase
         a_r5_wrap_flip: assert property (@(posedge clk) disable iff (!rst_n)
            wrap[g] |=> (ph[g] != $past(ph[g])));
      end
   endgenerate
endmodule

// File: rtl/cascade_pulse_timer.sv
module cascade_pulse_timer
   import cpt_pkg::*;
#(
   parameter int DW         = 8,
   parameter int AW         = 3,
   parameter bit CASCADE_EN = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [AW-1:0]      bus_addr,
   input  logic               bus_wr,
   input  logic               bus_rmw,
   input  logic [DW-1:0]      bus_wdata,
   output logic [DW-1:0]      bus_rdata,
   input  logic [NCH-1:0]     tick_in,
   input  logic [NCH-1:0]     gpio_out,
   output logic [NCH-1:0]     pin_out,
   output logic [NCH-1:0]     irq
);
   localparam int A_MODE = 2 * NCH + NCH;

   generate
      if (DW < 8) begin : g_bad_dw
         $error("cascade_pulse_timer: DW must be at least 8");
      end
      if ((1 << AW) <= A_MODE) begin : g_bad_aw
         $error("cascade_pulse_timer: AW too small for the register map");
      end
   endgenerate

   ctrl_t  [NCH-1:0]         ctrl;
   logic   [NCH-1:0][DW-1:0] ctrl_rd;
   logic   [NCH-1:0][DW-1:0] lo_q, hi_q;
   logic   [NCH-1:0]         pulse, wrap, run;
   logic                     mode_q;

   generate
      for (genvar g = 0; g < NCH; g++) begin : g_ch
         cpt_ctrl_reg #(.DW(DW)) u_ctrl (
            .clk   (clk),
            .rst_n (rst_n),
            .wr    (bus_wr && (bus_addr == AW'(g))),
            .rmw   (bus_rmw),
            .wdata (bus_wdata),
            .wrap  (wrap[g]),
            .ctrl  (ctrl[g]),
            .rdata (ctrl_rd[g])
         );

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               lo_q[g] <= '0;
               hi_q[g] <= '0;
            end else if (bus_wr) begin
               if (bus_addr == AW'(NCH + 2 * g))     lo_q[g] <= bus_wdata;
               if (bus_addr == AW'(NCH + 2 * g + 1)) hi_q[g] <= bus_wdata;
            end
         end

         assign run[g]     = ctrl[g].run;
         assign pin_out[g] = ctrl[g].psel ? pulse[g] : gpio_out[g];
         assign irq[g]     = ctrl[g].flag & ctrl[g].ien;

         // R4: no request while the enable is off
         a_r4_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
            irq[g] |-> ctrl[g].ien);
         // R3: port path when the pin is not selected
         a_r3_port_path: assert property (@(posedge clk) disable iff (!rst_n)
            !ctrl[g].psel |-> (pin_out[g] == gpio_out[g]));
      end

      if (CASCADE_EN) begin : g_mode
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               mode_q <= 1'b0;
            else if (bus_wr && (bus_addr == AW'(A_MODE)))
               mode_q <= bus_wdata[0];
         end
      end else begin : g_nomode
         assign mode_q = 1'b0;
      end
   endgenerate

   cpt_count_core #(.DW(DW), .CASCADE_EN(CASCADE_EN)) u_core (
      .clk     (clk),
      .rst_n   (rst_n),
      .cascade (mode_q),
      .run     (run),
      .tick    (tick_in),
      .lo_w    (lo_q),
      .hi_w    (hi_q),
      .pulse   (pulse),
      .wrap    (wrap)
   );

   always_comb begin
      bus_rdata = '0;
      for (int i = 0; i < NCH; i++) begin
         if (bus_addr == AW'(i))               bus_rdata = ctrl_rd[i];
         if (bus_addr == AW'(NCH + 2 * i))     bus_rdata = lo_q[i];
         if (bus_addr == AW'(NCH + 2 * i + 1)) bus_rdata = hi_q[i];
      end
      if (bus_addr == AW'(A_MODE)) bus_rdata = {{(DW-1){1'b0}}, mode_q};
   end

   // R2: a stopped channel 0 with the pin selected stays Low
   a_r2_idle_low0: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl[0].psel && !ctrl[0].run) |-> !pin_out[0]);
   // R6: in joined mode channel 1 never raises its own flag
   a_r6_no_hi_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      mode_q |-> !wrap[1]);
endmodule

// File: tb/cascade_pulse_timer_bench.sv
`timescale 1ns/1ps
module cascade_pulse_timer_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] bus_addr = '0;
   logic       bus_wr = 1'b0;
   logic       bus_rmw = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic [1:0] tick_in = '0;
   logic [1:0] gpio_out = '0;
   logic [1:0] pin_out;
   logic [1:0] irq;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;
   bit manual = 1;
   int dens [2];
   int exp_lo [2];
   int exp_hi [2];
   int seg [2];
   int toggles [2];
   bit mon_on [2];
   bit first [2];
   bit last_pin [2];
   string mon_req [2];
   logic [7:0] rv;

   always #2.5 clk = ~clk;

   cascade_pulse_timer u_cascade_pulse_timer (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_rmw(bus_rmw), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .tick_in(tick_in), .gpio_out(gpio_out), .pin_out(pin_out), .irq(irq)
   );

   function automatic int phase_ticks(int reload);
      return reload + 1;
   endfunction

   task automatic check(bit ok, string req, int act, int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic wr(int a, int d);
      @(negedge clk); #1;
      bus_addr = 3'(a); bus_wdata = 8'(d); bus_wr = 1'b1;
      @(negedge clk); #1;
      bus_wr = 1'b0;
   endtask

   task automatic rd(int a, bit rmw, output logic [7:0] v);
      @(negedge clk); #1;
      bus_addr = 3'(a); bus_rmw = rmw;
      #0.5;
      v = bus_rdata;
      bus_rmw = 1'b0;
   endtask

   task automatic arm(int i, string req);
      last_pin[i] = pin_out[i];
      seg[i] = 0; toggles[i] = 0; first[i] = 1; mon_req[i] = req; mon_on[i] = 1;
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
      #1;
   endtask

   // monitor then stimulus, once per falling edge
   always @(negedge clk) begin
      for (int i = 0; i < 2; i++) begin
         if (mon_on[i]) begin
            if (tick_in[i]) seg[i]++;
            if (pin_out[i] !== last_pin[i]) begin
               int want;
               want = last_pin[i] ? phase_ticks(exp_hi[i]) : phase_ticks(exp_lo[i]);
               check(seg[i] == want, first[i] ? "R11" : mon_req[i], seg[i], want);
               seg[i] = 0; first[i] = 0; toggles[i]++;
            end
            last_pin[i] = pin_out[i];
         end
      end
      if (!manual) begin
         for (int i = 0; i < 2; i++)
            tick_in[i] = (int'($urandom % 100) < dens[i]);
         gpio_out = 2'($urandom);
      end
   end

   // run both channels separately for one round
   task automatic round8(int l0, int h0, int l1, int h1, int d0, int d1);
      manual = 1; tick_in = '0;
      wr(6, 0);
      wr(2, l0); wr(3, h0); wr(4, l1); wr(5, h1);
      exp_lo[0] = l0; exp_hi[0] = h0; exp_lo[1] = l1; exp_hi[1] = h1;
      wr(0, 8'hA1); wr(1, 8'hA1);
      idle(1);
      arm(0, "R5"); arm(1, "R5");
      dens[0] = d0; dens[1] = d1; manual = 0;
      idle(3000);
      manual = 1; tick_in = '0;
      mon_on[0] = 0; mon_on[1] = 0;
      check(toggles[0] >= 2, "R5", toggles[0], 2);
      check(toggles[1] >= 2, "R5", toggles[1], 2);
      wr(0, 8'h29); wr(1, 8'h29);
      manual = 0; dens[0] = 100; dens[1] = 100;
      idle(5);
      check(pin_out == 2'b00, "R2", pin_out, 0);
      manual = 1; tick_in = '0;
   endtask

   task automatic round16(int l, int h, int d);
      manual = 1; tick_in = '0;
      wr(0, 8'h01); wr(1, 8'h21);
      wr(6, 1);
      wr(2, l & 255); wr(4, l >> 8); wr(3, h & 255); wr(5, h >> 8);
      exp_lo[0] = l; exp_hi[0] = h;
      wr(0, 8'hA1);
      idle(1);
      arm(0, "R6");
      dens[0] = d; dens[1] = 0; manual = 0;
      for (int k = 0; k < 3000; k++) begin
         @(negedge clk); #1;
         if (k % 50 == 0) check(pin_out[1] == pin_out[0], "R6", pin_out[1], pin_out[0]);
      end
      manual = 1; tick_in = '0; mon_on[0] = 0;
      check(toggles[0] >= 2, "R6", toggles[0], 2);
      rd(1, 0, rv);
      check(rv == 8'h21, "R6", rv, 8'h21);
      rd(0, 0, rv);
      check(rv[3] == 1'b1, "R6", rv[3], 1);
      wr(0, 8'h01); wr(6, 0);
   endtask

   initial begin
      void'($urandom(32'h5EED_0C7A));
      dens[0] = 0; dens[1] = 0;
      mon_on[0] = 0; mon_on[1] = 0;
      gpio_out = 2'b10;
      idle(3);
      rst_n = 1'b1;
      idle(2);

      // R1 reset state
      check(pin_out == gpio_out, "R1", pin_out, gpio_out);
      check(irq == 2'b00, "R1", irq, 0);
      for (int a = 0; a < 8; a++) begin
         rd(a, 0, rv);
         check(rv == ((a < 2) ? 8'h01 : 8'h00), "R1", rv, (a < 2) ? 1 : 0);
      end

      // separate channels: boundaries, then random
      round8(0, 255, 255, 0, 100, 100);
      for (int r = 0; r < 4; r++)
         round8($urandom % 256, $urandom % 256, $urandom % 256, $urandom % 256,
                40 + $urandom % 61, 40 + $urandom % 61);

      // flag and interrupt gating (channel 0 stopped, flag left set)
      rd(0, 0, rv);
      check(rv[3] == 1'b1, "R7", rv[3], 1);
      check(irq[0] == 1'b0, "R4", irq[0], 0);
      wr(0, 8'h39);
      rd(0, 0, rv);
      check(rv[3] == 1'b1, "R7", rv[3], 1);
      check(irq[0] == 1'b1, "R4", irq[0], 1);
      wr(0, 8'h31);
      rd(0, 0, rv);
      check(rv == 8'h31, "R7", rv, 8'h31);
      check(irq[0] == 1'b0, "R4", irq[0], 0);

      // reserved and unused bits
      wr(1, 8'h47);
      rd(1, 0, rv);
      check(rv == 8'h01, "R10", rv, 8'h01);
      wr(1, 8'h00);
      rd(1, 0, rv);
      check(rv == 8'h01, "R10", rv, 8'h01);
      rd(1, 1, rv);
      check(rv == 8'h09, "R9", rv, 8'h09);
      rd(1, 0, rv);
      check(rv == 8'h01, "R9", rv, 8'h01);

      // joined mode: borrow across the byte boundary, then random
      round16(256, 5, 70);
      round16($urandom % 600, $urandom % 600, 60 + $urandom % 41);

      // same-cycle wrap and clear
      manual = 1; tick_in = '0;
      wr(2, 0); wr(3, 0);
      wr(0, 8'hB1);
      idle(2);
      wr(0, 8'hB1);
      rd(0, 0, rv);
      check(rv[3] == 1'b0, "R7", rv[3], 0);
      @(negedge clk); #1;
      bus_addr = 3'd0; bus_wdata = 8'hB1; bus_wr = 1'b1; tick_in[0] = 1'b1;
      @(negedge clk); #1;
      bus_wr = 1'b0; tick_in[0] = 1'b0;
      rd(0, 0, rv);
      check(rv[3] == 1'b1, "R8", rv[3], 1);
      check(irq[0] == 1'b1, "R4", irq[0], 1);
      wr(0, 8'h01);

      // port path while counting
      wr(4, 3); wr(5, 2);
      wr(1, 8'h81);
      dens[1] = 100; manual = 0;
      for (int k = 0; k < 20; k++) begin
         @(negedge clk); #1;
         check(pin_out[1] == gpio_out[1], "R3", pin_out[1], gpio_out[1]);
      end
      manual = 1; tick_in = '0;

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      #(150000 * 5);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule